// File: doc/BRIEF.md
# Bang-Bang Clock-Recovery Phase Tracking Loop

This block is the digital control loop of a serial receiver's clock recovery. Every unit interval (one clock cycle) it receives the data sample taken at the centre of the current bit and an edge sample taken between the previous bit and the current one. A binary phase detector turns each data transition into a vote of one unit: the sampling clock is either early or late. It never gives a magnitude. Bits without a transition give no vote, so the vote rate follows the edge density of the line code. For example, 8b10b traffic has runs of up to 5 UI and carries edges on about 30 percent of bits.

Votes go into a signed accumulator with a threshold of plus or minus N. When the accumulator reaches the threshold, the loop moves the sampling phase by exactly one position and clears the accumulator. A spacing counter lets at most one move happen in any M unit intervals. The loop's slew is therefore capped at one step per M UI: with a 200 ps UI, a 5 ps step and M = 5, the cap is 5 ms/s. The phase code counts modulo the number of positions per UI. It can drive an interpolator directly or select one of several oversamples, and a constant frequency offset is tracked without end. A lock monitor watches the net movement in fixed windows. Once locked, the loop dithers by about one step around the ideal phase, which is expected for a bang-bang loop.

Top module: `cdr_track_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the phase code is set to NPOS/2 and `locked` to 0. Both values are visible after that edge.
- R2: A bit is a transition bit when `data_smp` differs from the previous data sample. On a transition bit, an edge sample equal to the previous bit is an "early" vote (+1). An edge sample equal to the current bit is a "late" vote (−1). A +N total raises the phase code by one, and a −N total lowers it by one.
- R3: A bit with no data transition casts no vote, whatever the edge sample is. A run of such bits leaves the phase code unchanged.
- R4: The accumulator saturates at ±ACC_N. With fewer than ACC_N net votes in one direction, no move is made. Opposite votes cancel one for one.
- R5: The accumulator is cleared in the cycle a move is made. Idle bits after a move therefore trigger no further move.
- R6: Two moves are at least STEP_GAP unit intervals apart. A threshold reached too early is held at saturation and executed as soon as the spacing allows.
- R7: Every move changes the phase code by exactly one position, modulo NPOS. NPOS−1 goes up to 0, and 0 goes down to NPOS−1. The code is always below NPOS.
- R8: `rec_bit` equals the `data_smp` value of the previous unit interval.
- R9: Time is divided into windows of WIN_UI unit intervals. Each window in which the net movement never goes beyond ±1 step adds to a run of good windows. `locked` rises at the end of the LOCK_WINS-th consecutive good window, and only at a window boundary.
- R10: When the net movement within a window reaches ±2 steps, `locked` drops at that clock edge. The window and the run of good windows restart at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One rising edge per unit interval |
| rst | input | 1 | Synchronous active-high reset |
| data_smp | input | 1 | Sample taken at the centre of the current bit |
| edge_smp | input | 1 | Sample taken at the boundary before the current bit |
| phase_code | output | $clog2(NPOS) | Selected sampling phase, 0..NPOS−1 |
| rec_bit | output | 1 | Recovered data bit, one UI delayed |
| locked | output | 1 | Lock indication from the window monitor |

## Verification
The loop is driven with four kinds of input. Pure idle runs with a noisy edge sample show that non-transition bits are ignored. Steady runs of early votes and of late votes show the threshold, the clearing after each move, the M-UI spacing and wrap-around in both directions. An alternating early/late dither pattern must produce lock at an exact window boundary, and a following one-sided run must break lock at the edge where the net movement reaches two steps. Long pseudo-random sweeps then compare every output in every unit interval against an arithmetic model. These sweeps use unbiased data, data with a strong early bias that mimics a frequency offset, and sparse transitions with runs of up to five bits; the bias separates a correct rate limit from a spacing error, and the sparse pattern separates held thresholds from lost ones.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;

    typedef enum logic [1:0] {
        PD_NONE  = 2'd0,
        PD_EARLY = 2'd1,
        PD_LATE  = 2'd2
    } pd_vote_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2
    } move_e;

    typedef struct packed {
        logic     rec;
        pd_vote_e vote;
    } pd_result_s;

    function automatic int unsigned wrap_move(int unsigned code, move_e mv, int unsigned npos);
        case (mv)
            MV_UP:   return (code == npos - 1) ? 0 : code + 1;
            MV_DOWN: return (code == 0) ? npos - 1 : code - 1;
            default: return code;
        endcase
    endfunction

endpackage

// File: rtl/cdr_bbpd.sv
`timescale 1ns/1ps
module cdr_bbpd
    import cdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       data_i,
    input  logic       edge_i,
    output pd_result_s res_o
);
    logic prev_q;
    logic rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            rec_q  <= 1'b0;
        end else begin
            prev_q <= data_i;
            rec_q  <= data_i;
        end
    end

    always_comb begin
        res_o.rec = rec_q;
        if (data_i == prev_q)
            res_o.vote = PD_NONE;
        else if (edge_i == prev_q)
            res_o.vote = PD_EARLY;
        else
            res_o.vote = PD_LATE;
    end
endmodule

// File: rtl/cdr_vote_filter.sv
`timescale 1ns/1ps
module cdr_vote_filter
    import cdr_pkg::*;
#(
    parameter int ACC_N    = 4,
    parameter int STEP_GAP = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  pd_vote_e vote_i,
    output move_e    move_o
);
    localparam int ACC_W = $clog2(ACC_N + 2) + 1;
    localparam int GAP_W = $clog2(STEP_GAP + 1);
    localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(ACC_N);
    localparam logic signed [ACC_W-1:0] ACC_MIN = -ACC_MAX;
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(STEP_GAP);

    logic signed [ACC_W-1:0] acc_q, acc_sum, acc_clip;
    logic [GAP_W-1:0]        gap_q;
    logic                    gap_ok;

    always_comb begin
        case (vote_i)
            PD_EARLY: acc_sum = acc_q + ACC_W'(1);
            PD_LATE:  acc_sum = acc_q - ACC_W'(1);
            default:  acc_sum = acc_q;
        endcase
        if (acc_sum > ACC_MAX)      acc_clip = ACC_MAX;
        else if (acc_sum < ACC_MIN) acc_clip = ACC_MIN;
        else                        acc_clip = acc_sum;

        gap_ok = (gap_q >= GAP_FULL);
        if (gap_ok && acc_clip == ACC_MAX)      move_o = MV_UP;
        else if (gap_ok && acc_clip == ACC_MIN) move_o = MV_DOWN;
        else                                    move_o = MV_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            gap_q <= GAP_FULL;
        end else if (move_o != MV_HOLD) begin
            acc_q <= '0;
            gap_q <= GAP_W'(1);
        end else begin
            acc_q <= acc_clip;
            gap_q <= gap_ok ? GAP_FULL : gap_q + GAP_W'(1);
        end
    end

    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_q <= ACC_MAX) && (acc_q >= ACC_MIN));
endmodule

// File: rtl/cdr_phase_reg.sv
`timescale 1ns/1ps
module cdr_phase_reg
    import cdr_pkg::*;
#(
    parameter int NPOS   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  move_e             move_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(NPOS / 2);

    always_ff @(posedge clk) begin
        if (rst) code_o <= CODE_MID;
        else     code_o <= CODE_W'(wrap_move(32'(code_o), move_i, NPOS));
    end

    assert_code_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(code_o) < NPOS);
endmodule

// File: rtl/cdr_lock_mon.sv
`timescale 1ns/1ps
module cdr_lock_mon
    import cdr_pkg::*;
#(
    parameter int WIN_UI    = 64,
    parameter int LOCK_WINS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  move_e move_i,
    output logic  locked_o
);
    localparam int WIN_W  = $clog2(WIN_UI);
    localparam int GOOD_W = $clog2(LOCK_WINS + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_UI - 1);
    localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(LOCK_WINS);

    logic [WIN_W-1:0]  win_q;
    logic [GOOD_W-1:0] good_q, good_n;
    logic signed [2:0] net_q, net_n;
    logic              exceed;

    always_comb begin
        case (move_i)
            MV_UP:   net_n = net_q + 3'sd1;
            MV_DOWN: net_n = net_q - 3'sd1;
            default: net_n = net_q;
        endcase
        exceed = (net_n > 3'sd1) || (net_n < -3'sd1);
        good_n = (good_q == GOOD_FULL) ? good_q : good_q + GOOD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || exceed) begin
            win_q    <= '0;
            net_q    <= '0;
            good_q   <= '0;
            locked_o <= 1'b0;
        end else if (win_q == WIN_LAST) begin
            win_q  <= '0;
            net_q  <= '0;
            good_q <= good_n;
            if (good_n >= GOOD_FULL) locked_o <= 1'b1;
        end else begin
            win_q <= win_q + WIN_W'(1);
            net_q <= net_n;
        end
    end

    assert_lock_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> (win_q == '0));
endmodule

// File: rtl/cdr_track_loop.sv
`timescale 1ns/1ps
module cdr_track_loop
    import cdr_pkg::*;
#(
    parameter int NPOS      = 32,
    parameter int ACC_N     = 4,
    parameter int STEP_GAP  = 5,
    parameter int WIN_UI    = 64,
    parameter int LOCK_WINS = 4,
    localparam int CODE_W   = (NPOS > 1) ? $clog2(NPOS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_smp,
    input  logic              edge_smp,
    output logic [CODE_W-1:0] phase_code,
    output logic              rec_bit,
    output logic              locked
);
    pd_result_s pd_res;
    move_e      move;

    cdr_bbpd u_pd (
        .clk    (clk),
        .rst    (rst),
        .data_i (data_smp),
        .edge_i (edge_smp),
        .res_o  (pd_res)
    );

    cdr_vote_filter #(.ACC_N(ACC_N), .STEP_GAP(STEP_GAP)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .vote_i (pd_res.vote),
        .move_o (move)
    );

    cdr_phase_reg #(.NPOS(NPOS), .CODE_W(CODE_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .move_i (move),
        .code_o (phase_code)
    );

    cdr_lock_mon #(.WIN_UI(WIN_UI), .LOCK_WINS(LOCK_WINS)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .move_i   (move),
        .locked_o (locked)
    );

    assign rec_bit = pd_res.rec;

    // Observation of the output code: last value and UIs since it last moved.
    localparam int SINCE_W = $clog2(STEP_GAP + 1);
    logic [CODE_W-1:0]  last_code_q;
    logic [SINCE_W-1:0] since_q;
    logic               code_moved;

    assign code_moved = (phase_code != last_code_q);

    always_ff @(posedge clk) begin
        last_code_q <= phase_code;
        if (rst)
            since_q <= SINCE_W'(STEP_GAP);
        else if (code_moved)
            since_q <= SINCE_W'(1);
        else if (since_q != SINCE_W'(STEP_GAP))
            since_q <= since_q + SINCE_W'(1);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (32'(phase_code) == NPOS / 2) && !locked);

    assert_step_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        code_moved |-> (32'(since_q) >= STEP_GAP));

    assert_unit_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        code_moved |-> ((32'(phase_code) == (32'(last_code_q) + 1) % NPOS) ||
                        (32'(phase_code) == (32'(last_code_q) + NPOS - 1) % NPOS)));
endmodule

// File: tb/cdr_track_loop_test.sv
`timescale 1ns/1ps
module cdr_track_loop_test;
    localparam int NPOS = 8;
    localparam int ACCN = 3;
    localparam int GAP  = 4;
    localparam int WIN  = 12;
    localparam int LW   = 3;
    localparam int CW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_smp = 1'b0;
    logic edge_smp = 1'b0;
    logic [CW-1:0] phase_code;
    logic rec_bit, locked;

    cdr_track_loop #(.NPOS(NPOS), .ACC_N(ACCN), .STEP_GAP(GAP),
                     .WIN_UI(WIN), .LOCK_WINS(LW)) uut (
        .clk(clk), .rst(rst), .data_smp(data_smp), .edge_smp(edge_smp),
        .phase_code(phase_code), .rec_bit(rec_bit), .locked(locked)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int m_prev, m_acc, m_gap, m_code, m_net, m_win, m_good, m_lock, m_rec;
    int ui_n, last_chg, seen_code;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; data_smp = 1'b0; edge_smp = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_prev = 0; m_acc = 0; m_gap = GAP; m_code = NPOS / 2;
        m_net = 0; m_win = 0; m_good = 0; m_lock = 0; m_rec = 0;
        ui_n = 0; last_chg = -100; seen_code = NPOS / 2;
    endtask

    // One unit interval: drive, model the expected effect, compare after the edge.
    task automatic ui(input logic d, input logic e);
        int vote, an, st, nn;
        data_smp = d; edge_smp = e;
        @(posedge clk);
        vote = (int'(d) != m_prev) ? ((int'(e) == m_prev) ? 1 : -1) : 0;
        an = m_acc + vote;
        if (an > ACCN) an = ACCN;
        if (an < -ACCN) an = -ACCN;
        st = 0;
        if (m_gap >= GAP) st = (an == ACCN) ? 1 : ((an == -ACCN) ? -1 : 0);
        if (st != 0) begin m_acc = 0; m_gap = 1; end
        else begin m_acc = an; m_gap = (m_gap < GAP) ? m_gap + 1 : GAP; end
        m_code = (m_code + st + NPOS) % NPOS;
        m_prev = int'(d); m_rec = int'(d);
        nn = m_net + st;
        if (nn > 1 || nn < -1) begin
            m_net = 0; m_win = 0; m_good = 0; m_lock = 0;
        end else if (m_win == WIN - 1) begin
            m_win = 0; m_net = 0;
            if (m_good < LW) m_good++;
            if (m_good >= LW) m_lock = 1;
        end else begin
            m_win++; m_net = nn;
        end
        @(negedge clk);
        check(cur_req, int'(phase_code), m_code);
        check({cur_req, "/R8"}, int'(rec_bit), m_rec);
        check({cur_req, "/R9"}, int'(locked), m_lock);
        if (int'(phase_code) != seen_code) begin
            checks++;
            if (ui_n - last_chg < GAP) begin
                fails++;
                $display("FAIL R6 spacing actual=%0d expected>=%0d", ui_n - last_chg, GAP);
            end
            last_chg = ui_n;
            seen_code = int'(phase_code);
        end
        ui_n++;
    endtask

    task automatic early_v(); ui(~m_prev[0], m_prev[0]); endtask
    task automatic late_v();  ui(~m_prev[0], ~m_prev[0]); endtask
    task automatic idle_v();  ui(m_prev[0], ~m_prev[0]); endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 code", int'(phase_code), NPOS / 2);
        check("R1 lock", int'(locked), 0);

        // R3: no transitions, noisy edge sample
        cur_req = "R3";
        repeat (20) idle_v();
        check("R3 code", int'(phase_code), 4);

        // R4 / R2: threshold of three early votes
        do_reset();
        cur_req = "R4";
        early_v(); early_v();
        check("R4 below threshold", int'(phase_code), 4);
        late_v(); early_v();
        check("R4 cancel", int'(phase_code), 4);
        cur_req = "R2";
        early_v();
        check("R2 early step up", int'(phase_code), 5);

        // R5: cleared after move, idle does not re-trigger
        cur_req = "R5";
        repeat (4) idle_v();
        check("R5 cleared", int'(phase_code), 5);
        early_v(); early_v();
        check("R5 two votes", int'(phase_code), 5);
        early_v();
        check("R5 third vote", int'(phase_code), 6);

        // R6 / R7: steady early votes, one move per 4 UI, wrap upward
        cur_req = "R6";
        repeat (16) early_v();
        check("R6/R7 code after 16 UI", int'(phase_code), 2);

        // R7: steady late votes, wrap downward
        do_reset();
        cur_req = "R7";
        repeat (19) late_v();
        check("R7 down wrap", int'(phase_code), 7);

        // R8: recovered bit delay
        cur_req = "R8";
        ui(1'b1, 1'b0);
        check("R8 one", int'(rec_bit), 1);
        ui(1'b0, 1'b0);
        check("R8 zero", int'(rec_bit), 0);

        // R9: dither pattern locks at the third window end
        do_reset();
        cur_req = "R9";
        for (int p = 0; p < 4; p++) begin
            repeat (3) early_v(); idle_v();
            repeat (3) late_v(); idle_v();
        end
        repeat (3) early_v();
        check("R9 before lock", int'(locked), 0);
        idle_v();
        check("R9 lock", int'(locked), 1);

        // R10: one-sided run breaks lock when net reaches 2
        cur_req = "R10";
        repeat (6) early_v();
        check("R10 still locked", int'(locked), 1);
        early_v();
        check("R10 lock lost", int'(locked), 0);

        // Sweeps against the model
        do_reset();
        cur_req = "R2 sweep random";
        for (int i = 0; i < 2000; i++) ui(rnd(), rnd());
        do_reset();
        cur_req = "R6 sweep biased";
        for (int i = 0; i < 2000; i++) begin
            logic d;
            logic biased;
            d = rnd();
            biased = rnd() | rnd();
            ui(d, biased ? m_prev[0] : d);
        end
        do_reset();
        cur_req = "R3 sweep sparse";
        for (int i = 0; i < 2000; i++) begin
            logic flip;
            flip = rnd() & rnd() & (rnd() | rnd());
            if ((i % 5) == 4) flip = 1'b1;
            ui(flip ? ~m_prev[0] : m_prev[0], rnd());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule